// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns 24 external pins into interrupt requests for a main interrupt controller. Every pin passes through a two-flop synchroniser, and each pin has its own trigger mode. A pin raises an event only when its pin-function field selects the interrupt function. Pins 0 to 3 are the fast pins. Each of them has its own request line straight to the main controller, with no pending or mask state in this block.

Pins 4 to 23 each keep a pending flag and a mask bit. Software clears a pending flag by writing 1 to it, and a mask bit of 1 blocks the pin. Unmasked pending pins 4 to 7 share one parent request line, and unmasked pending pins 8 to 23 share a second one. A wake-enable register lets pins 0 to 15 raise a wake request. A simple single-cycle register bus gives access to all configuration and status.

Top module: `eint_ctrl`

## Requirements
- R1: Trigger modes are stored as 3-bit fields. Pins 0-7 are at address 0, pins 8-15 at address 1 and pins 16-23 at address 2, each at bit 4*(pin mod 8). Bit 3 of every nibble reads 0. Read data appears on `bus_rdata` the cycle after `bus_addr` is presented.
- R2: The mode codes are 000 low level, 001 high level, 01x falling edge, 10x rising edge and 11x both edges. Edges are judged on the synchronised pin value. An edge event lasts one cycle, and a level event lasts as long as the level holds.
- R3: Each pin has a 2-bit function field at bit 2*(pin mod 16). Pins 0-15 are at address 3 and pins 16-23 at address 4, and bits above pin 23 read 0. A pin produces events only when its field holds 2 (binary 10).
- R4: Address 5 holds one pending bit per pin at bit position equal to the pin number, for pins 4-23. An event sets the bit, and writing 1 to the bit clears it. Bits 0-3 always read 0.
- R5: For a pin in a level mode with its level active, the pending bit stays set in the cycle after a clear is written.
- R6: Address 6 holds one mask bit per pin for pins 4-23, and it resets to 0x00FFFFF0. A masked pin still records pending, but it never drives a parent line.
- R7: `irq_grp_lo_o` is high when any unmasked pending pin lies in 4-7, and `irq_grp_hi_o` is high when any lies in 8-23. Each line follows the pending state one cycle later. With the 2-flop synchroniser this gives 4 cycles from a pin change to the parent line.
- R8: Pins 0-3 drive `irq_direct_o[3:0]` directly, with no pending or mask state. The output is high 3 cycles after the pin change. For edge modes it is a single-cycle pulse.
- R9: Address 7 is the wake-enable register. Only bits 0-15 can be written, and writes to bits 16-23 are ignored and read 0. `wake_o` pulses one cycle after an event on a wake-enabled pin.
- R10: After reset the configuration, function, pending and wake registers are zero, the mask is 0x00FFFFF0, and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 24 | Asynchronous external pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for last cycle's address |
| irq_direct_o | output | 4 | Individual requests for pins 0-3 |
| irq_grp_lo_o | output | 1 | Shared request for pins 4-7 |
| irq_grp_hi_o | output | 1 | Shared request for pins 8-23 |
| wake_o | output | 1 | Wake request from enabled pins 0-15 |

## Verification
The assertions watch several rules on every cycle. A rising-mode pin never fires twice in a row. A level event always keeps its pending bit set, and a clear without a new event drops it. A parent line never rises without pending in its range, and never rises when its whole range is masked. Direct lines and the wake line only follow pins whose function field selects interrupts. The register layout, the reset values, the exact cycle latencies and the ignored wake bits can only be shown by the bench scenarios. The same holds for the mode decoding across random configurations, and for how pending evolves across many pin patterns.

// File: rtl/eint_pkg.sv
package eint_pkg;

  typedef enum logic [2:0] {
    TRIG_LOW,
    TRIG_HIGH,
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH
  } trig_e;

  // function-field value that routes a pin to the interrupt logic
  localparam logic [1:0] FN_IRQ = 2'b10;

  function automatic trig_e decode_trig(input logic [2:0] f);
    trig_e k;
    case (f[2:1])
      2'b00:   k = f[0] ? TRIG_HIGH : TRIG_LOW;
      2'b01:   k = TRIG_FALL;
      2'b10:   k = TRIG_RISE;
      default: k = TRIG_BOTH;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);

  logic [N-1:0] meta_q;

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= pin_i;
      sync_o <= meta_q;
      prev_o <= sync_o;
    end
  end

endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int N = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   sync_i,
  input  logic [N-1:0]   prev_i,
  input  logic [3*N-1:0] mode_i,
  input  logic [2*N-1:0] fn_i,
  output logic [N-1:0]   evt_o
);

  for (genvar p = 0; p < N; p++) begin : g_pin
    trig_e kind;
    logic  hit;

    assign kind = decode_trig(mode_i[3*p +: 3]);

    always_comb begin
      case (kind)
        TRIG_LOW:  hit = !sync_i[p];
        TRIG_HIGH: hit = sync_i[p];
        TRIG_FALL: hit = prev_i[p] && !sync_i[p];
        TRIG_RISE: hit = !prev_i[p] && sync_i[p];
        default:   hit = prev_i[p] ^ sync_i[p];
      endcase
    end

    assign evt_o[p] = hit && (fn_i[2*p +: 2] == FN_IRQ);

    // R2: a rising-edge event cannot repeat on the next cycle under the same mode
    a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
      (kind == TRIG_RISE && evt_o[p]) |=> !(evt_o[p] && $stable(mode_i[3*p +: 3])));
  end

endmodule

// File: rtl/eint_regs.sv
module eint_regs #(
  parameter int N         = 24,
  parameter int NDIR      = 4,
  parameter int WAKE_PINS = 16,
  parameter int DW        = 32,
  parameter int AW        = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [N-1:0]   evt_i,
  output logic [3*N-1:0] mode_o,
  output logic [2*N-1:0] fn_o,
  output logic [N-1:0]   pend_o,
  output logic [N-1:0]   mask_o,
  output logic [N-1:0]   wake_en_o,
  output logic [DW-1:0]  rdata_o
);

  localparam int CPR  = DW / 4;            // pins per trigger register
  localparam int FPR  = DW / 2;            // pins per function register
  localparam int NCFG = (N + CPR - 1) / CPR;
  localparam int NFN  = (N + FPR - 1) / FPR;
  localparam logic [AW-1:0] A_FN0  = AW'(NCFG);
  localparam logic [AW-1:0] A_PEND = AW'(NCFG + NFN);
  localparam logic [AW-1:0] A_MASK = AW'(NCFG + NFN + 1);
  localparam logic [AW-1:0] A_WAKE = AW'(NCFG + NFN + 2);
  localparam logic [N-1:0]  EXT_BITS  = {{(N-NDIR){1'b1}}, {NDIR{1'b0}}};
  localparam logic [N-1:0]  WAKE_BITS = {{(N-WAKE_PINS){1'b0}}, {WAKE_PINS{1'b1}}};

  function automatic logic [DW-1:0] cfg_keep(input int r);
    logic [DW-1:0] k = '0;
    for (int j = 0; j < CPR; j++)
      if (r * CPR + j < N) k[4*j +: 3] = 3'b111;
    return k;
  endfunction

  function automatic logic [DW-1:0] fn_keep(input int r);
    logic [DW-1:0] k = '0;
    for (int j = 0; j < FPR; j++)
      if (r * FPR + j < N) k[2*j +: 2] = 2'b11;
    return k;
  endfunction

  logic [NCFG-1:0][DW-1:0] cfg_q;
  logic [NFN-1:0][DW-1:0]  fn_q;
  logic [N-1:0]            pend_q, mask_q, wake_q, clr;
  logic [DW-1:0]           rd;

  assign clr = (we && addr == A_PEND) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      fn_q   <= '0;
      pend_q <= '0;
      mask_q <= EXT_BITS;
      wake_q <= '0;
    end else begin
      // a live event wins over a clear in the same cycle
      pend_q <= ((pend_q & ~clr) | evt_i) & EXT_BITS;
      if (we) begin
        for (int r = 0; r < NCFG; r++)
          if (addr == AW'(r)) cfg_q[r] <= wdata & cfg_keep(r);
        for (int r = 0; r < NFN; r++)
          if (addr == AW'(NCFG + r)) fn_q[r] <= wdata & fn_keep(r);
        if (addr == A_MASK) mask_q <= wdata[N-1:0] & EXT_BITS;
        if (addr == A_WAKE) wake_q <= wdata[N-1:0] & WAKE_BITS;
      end
    end
  end

  always_comb begin
    rd = '0;
    for (int r = 0; r < NCFG; r++)
      if (addr == AW'(r)) rd = cfg_q[r];
    for (int r = 0; r < NFN; r++)
      if (addr == AW'(r) + A_FN0) rd = fn_q[r];
    if (addr == A_PEND) rd[N-1:0] = pend_q;
    if (addr == A_MASK) rd[N-1:0] = mask_q;
    if (addr == A_WAKE) rd[N-1:0] = wake_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd;
  end

  for (genvar p = 0; p < N; p++) begin : g_map
    assign mode_o[3*p +: 3] = cfg_q[p / CPR][4*(p % CPR) +: 3];
    assign fn_o[2*p +: 2]   = fn_q[p / FPR][2*(p % FPR) +: 2];
  end

  assign pend_o    = pend_q;
  assign mask_o    = mask_q;
  assign wake_en_o = wake_q;

  for (genvar p = NDIR; p < N; p++) begin : g_chk
    // R4: a clear with no event on the same cycle drops the flag
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (clr[p] && !evt_i[p]) |=> !pend_q[p]);
    // R5: an event always leaves the flag set, whatever was written
    a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
      evt_i[p] |=> pend_q[p]);
  end

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int N         = 24,
  parameter int NDIR      = 4,
  parameter int SPLIT     = 8,
  parameter int WAKE_PINS = 16,
  parameter int DW        = 32,
  parameter int AW        = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    pin_i,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NDIR-1:0] irq_direct_o,
  output logic            irq_grp_lo_o,
  output logic            irq_grp_hi_o,
  output logic            wake_o
);

  localparam logic [N-1:0] LO_BITS = {{(N-SPLIT){1'b0}}, {(SPLIT-NDIR){1'b1}}, {NDIR{1'b0}}};
  localparam logic [N-1:0] HI_BITS = {{(N-SPLIT){1'b1}}, {SPLIT{1'b0}}};

  logic [N-1:0]   sync, prev, evt, pend, mask, wake_en;
  logic [3*N-1:0] mode;
  logic [2*N-1:0] fn;

  eint_sync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sync_o(sync), .prev_o(prev)
  );

  eint_detect #(.N(N)) u_detect (
    .clk(clk), .rst(rst), .sync_i(sync), .prev_i(prev),
    .mode_i(mode), .fn_i(fn), .evt_o(evt)
  );

  eint_regs #(.N(N), .NDIR(NDIR), .WAKE_PINS(WAKE_PINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .evt_i(evt), .mode_o(mode), .fn_o(fn), .pend_o(pend), .mask_o(mask),
    .wake_en_o(wake_en), .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_direct_o <= '0;
      irq_grp_lo_o <= 1'b0;
      irq_grp_hi_o <= 1'b0;
      wake_o       <= 1'b0;
    end else begin
      irq_direct_o <= evt[NDIR-1:0];
      irq_grp_lo_o <= |(pend & ~mask & LO_BITS);
      irq_grp_hi_o <= |(pend & ~mask & HI_BITS);
      wake_o       <= |(evt & wake_en);
    end
  end

  // R7: the low parent line needs a pending flag in its range the cycle before
  a_r7_lo_has_source: assert property (@(posedge clk) disable iff (rst)
    irq_grp_lo_o |-> $past(|(pend & LO_BITS)));

  // R6: a fully masked high range keeps its parent line low
  a_r6_hi_all_masked: assert property (@(posedge clk) disable iff (rst)
    ((mask & HI_BITS) == HI_BITS) |=> !irq_grp_hi_o);

  // R9: wake can only come from an event among the wake-capable pins
  a_r9_wake_source: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(|evt[WAKE_PINS-1:0]));

  for (genvar p = 0; p < NDIR; p++) begin : g_dir_chk
    // R8: a direct line rises only for a pin routed to the interrupt function
    a_r8_direct_gated: assert property (@(posedge clk) disable iff (rst)
      irq_direct_o[p] |-> $past(fn[2*p +: 2] == FN_IRQ));
  end

endmodule

// File: tb/eint_ctrl_tb.sv
`timescale 1ns/1ps
module eint_ctrl_tb;

  localparam logic [23:0] EXT = 24'hFFFFF0;
  localparam logic [23:0] LO  = 24'h0000F0;
  localparam logic [23:0] HI  = 24'hFFFF00;

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] pins;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq_dir;
  logic        grp_lo, grp_hi, wake;

  int checks = 0;
  int errors = 0;

  logic [2:0]  mode_m [24];
  logic [1:0]  fn_m   [24];
  logic [23:0] mask_m, pend_m, wake_m;

  always #2.5 clk = ~clk;

  eint_ctrl u_dut (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_direct_o(irq_dir),
    .irq_grp_lo_o(grp_lo), .irq_grp_hi_o(grp_hi), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic lvl_act(input logic [2:0] m, input logic v);
    return (m == 3'b000 && !v) || (m == 3'b001 && v);
  endfunction

  function automatic logic edge_hit(input logic [2:0] m, input logic o, input logic n);
    case (m[2:1])
      2'b01:   return o && !n;
      2'b10:   return !o && n;
      2'b11:   return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] lvl_bits(input logic [23:0] v);
    logic [23:0] b = '0;
    for (int p = 0; p < 24; p++)
      b[p] = (fn_m[p] == 2'b10) && lvl_act(mode_m[p], v[p]);
    return b;
  endfunction

  function automatic logic [31:0] fn_word(input int r);
    logic [31:0] w = '0;
    for (int j = 0; j < 16; j++)
      if (r * 16 + j < 24) w[2*j +: 2] = fn_m[r*16 + j];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [23:0] newp, c;
    logic        seen;
    void'($urandom(32'd2024));
    rst = 1'b1; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    cycles(4);
    rst = 1'b0;
    cycles(1);

    // R10: reset state
    check("R10 outputs", {25'd0, irq_dir, grp_lo, grp_hi, wake}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), d);
      check(a == 6 ? "R6 mask reset" : "R10 reg reset", d, a == 6 ? 32'h00FFFFF0 : 32'h0);
    end

    // R1: field layout, spare nibble bits read 0
    bus_wr(3'd0, 32'hFFFFFFFF); bus_rd(3'd0, d); check("R1 cfg0 keep", d, 32'h77777777);
    bus_wr(3'd2, 32'h12345678); bus_rd(3'd2, d); check("R1 cfg2 keep", d, 32'h12345670);
    bus_wr(3'd0, 0); bus_wr(3'd2, 0);
    // R3: function register bits beyond pin 23
    bus_wr(3'd4, 32'hFFFFFFFF); bus_rd(3'd4, d); check("R3 fn hi keep", d, 32'h0000FFFF);
    bus_wr(3'd4, 0);
    // R9: wake bits for pins 16-23 ignored
    bus_wr(3'd7, 32'hFFFFFFFF); bus_rd(3'd7, d); check("R9 wake keep", d, 32'h0000FFFF);
    bus_wr(3'd7, 0);
    // R6: mask bits 0-3 not writable
    bus_wr(3'd6, 32'hFFFFFFFF); bus_rd(3'd6, d); check("R6 mask keep", d, 32'h00FFFFF0);

    // direct pins: p0 rise, p1 fall, p2 high, p3 high but function off; p5 rise
    bus_wr(3'd0, 32'h00401124);
    bus_wr(3'd3, 32'h0000082A);
    pins[1] = 1'b1; cycles(6);
    check("R2 falling ignores rise", {28'd0, irq_dir}, 32'd0);
    pins[0] = 1'b1; cycles(3);
    check("R8 direct rise latency", {31'd0, irq_dir[0]}, 32'd1);
    cycles(1);
    check("R8 direct edge pulse", {31'd0, irq_dir[0]}, 32'd0);
    pins[1] = 1'b0; cycles(3);
    check("R2 falling edge", {28'd0, irq_dir}, 32'h2);
    pins[3:2] = 2'b11; cycles(3);
    check("R3 function gate", {28'd0, irq_dir}, 32'h4);
    cycles(5);
    check("R2 high level holds", {28'd0, irq_dir}, 32'h4);
    pins[3:2] = 2'b00; cycles(3);
    check("R2 level released", {28'd0, irq_dir}, 32'h0);

    // R4/R7: pin 5 through pending to the low parent
    bus_wr(3'd6, 32'h00FFFFDF);
    pins[5] = 1'b1; cycles(4);
    check("R7 low parent", {30'd0, grp_lo, grp_hi}, 32'h2);
    bus_rd(3'd5, d); check("R4 pending set", d, 32'h20);
    bus_wr(3'd5, 32'h20); cycles(1);
    check("R7 parent drops after clear", {31'd0, grp_lo}, 32'd0);
    bus_rd(3'd5, d); check("R4 pending cleared", d, 32'h0);
    pins[5] = 1'b0;

    // R6: masked pin 9 records but stays off the parent until unmasked
    bus_wr(3'd1, 32'h00000040);
    bus_wr(3'd3, 32'h0008082A);
    pins[9] = 1'b1; cycles(5);
    check("R6 masked quiet", {31'd0, grp_hi}, 32'd0);
    bus_rd(3'd5, d); check("R6 masked still pending", d, 32'h200);
    bus_wr(3'd6, 32'h00FFFDDF); cycles(1);
    check("R7 high parent after unmask", {31'd0, grp_hi}, 32'd1);
    bus_wr(3'd5, 32'h200); pins[9] = 1'b0;

    // R5: low-level pin 20 survives a clear while held low
    bus_wr(3'd6, 32'h00EFFDDF);
    bus_wr(3'd4, 32'h00000200);
    cycles(3);
    bus_rd(3'd5, d); check("R2 low level pending", d, 32'h100000);
    bus_wr(3'd5, 32'h100000);
    bus_rd(3'd5, d); check("R5 level beats clear", d, 32'h100000);
    check("R7 high parent level", {31'd0, grp_hi}, 32'd1);
    pins[20] = 1'b1; cycles(4);
    bus_wr(3'd5, 32'h100000);
    bus_rd(3'd5, d); check("R5 clear after release", d, 32'h0);
    check("R7 high parent idle", {31'd0, grp_hi}, 32'd0);

    // R2: both edges on pin 12
    bus_wr(3'd1, 32'h00060040);
    bus_wr(3'd3, 32'h0208082A);
    pins[12] = 1'b1; cycles(4);
    bus_rd(3'd5, d); check("R2 both rise", d, 32'h1000);
    bus_wr(3'd5, 32'h1000);
    pins[12] = 1'b0; cycles(4);
    bus_rd(3'd5, d); check("R2 both fall", d, 32'h1000);
    bus_wr(3'd5, 32'h1000);

    // R9: wake from pin 10, never from pin 16
    bus_wr(3'd1, 32'h00060440);
    bus_wr(3'd3, 32'h0228082A);
    bus_wr(3'd2, 32'h00000004);
    bus_wr(3'd4, 32'h00000202);
    bus_wr(3'd7, 32'h00010400);
    pins[10] = 1'b1; cycles(3);
    check("R9 wake pulse", {31'd0, wake}, 32'd1);
    pins[16] = 1'b1; seen = 1'b0;
    for (int i = 0; i < 6; i++) begin cycles(1); seen |= wake; end
    check("R9 pin16 no wake", {31'd0, seen}, 32'd0);

    // random phase from a clean reset
    pins = '0; rst = 1'b1; cycles(3); rst = 1'b0;
    pend_m = '0;
    for (int it = 0; it < 60; it++) begin
      bus_wr(3'd3, 0); bus_wr(3'd4, 0);
      for (int r = 0; r < 3; r++) begin
        d = $urandom & 32'h77777777;
        bus_wr(3'(r), d);
        for (int j = 0; j < 8; j++) mode_m[8*r + j] = d[4*j +: 3];
      end
      for (int p = 0; p < 24; p++)
        fn_m[p] = ($urandom_range(3, 0) == 0) ? 2'($urandom) : 2'b10;
      bus_wr(3'd3, fn_word(0)); bus_wr(3'd4, fn_word(1));
      mask_m = 24'($urandom) & EXT; bus_wr(3'd6, {8'd0, mask_m});
      wake_m = 24'($urandom) & 24'h00FFFF; bus_wr(3'd7, {8'd0, wake_m});
      bus_wr(3'd5, 32'hFFFFFFFF);
      pend_m = lvl_bits(pins) & EXT;

      newp = 24'($urandom);
      for (int p = 4; p < 24; p++)
        if (fn_m[p] == 2'b10 && (edge_hit(mode_m[p], pins[p], newp[p]) || lvl_act(mode_m[p], newp[p])))
          pend_m[p] = 1'b1;
      pins = newp; cycles(6);
      bus_rd(3'd5, d); check("R4 random pending", d, {8'd0, pend_m});
      check("R7 random parents", {30'd0, grp_lo, grp_hi},
            {30'd0, |(pend_m & ~mask_m & LO), |(pend_m & ~mask_m & HI)});
      check("R8 random direct", {28'd0, irq_dir}, {28'd0, lvl_bits(pins) & 24'hF});
      check("R9 random wake", {31'd0, wake}, {31'd0, |(lvl_bits(pins) & wake_m)});

      c = 24'($urandom);
      bus_wr(3'd5, {8'd0, c});
      pend_m = (pend_m & ~c) | (lvl_bits(pins) & EXT);
      bus_rd(3'd5, d); check("R5 random partial clear", d, {8'd0, pend_m});
    end

    finish_run();
  end

endmodule